// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a word-wide main memory. It holds eight 32-bit words, arranged as four sets of two ways, with one word per line. A 7-bit byte address is split into a tag, a set number and a byte offset. Both ways of the selected set are looked up at the same time, and a 2-to-1 select returns the matching word. Reads and writes that hit are served in the cache without touching memory. A write hit marks its line dirty.

On a miss the block holds the requester off. It picks a victim way: an empty way first, otherwise the least recently used way of that set. A dirty victim is written back to memory first. The block then fetches the missing word and completes the original access. Write misses allocate: the store is merged into the freshly fetched line, and that line is left dirty.

Both data-carrying sides use valid/ready. The processor presents a request with `req_valid`. The request is taken on a clock edge where `req_ready` is high. While the cache is working on a miss, `req_ready` stays low and the requester must keep waiting. The memory side raises `mem_valid` and holds the address, write enable and data unchanged until memory answers with `mem_ready`. On a read, memory supplies `mem_rdata` in the same cycle as `mem_ready`. Memory may stall for as many cycles as it likes.

Top module: `wbc_cache`

## Requirements
- R1: The byte address is split as tag = bits [6:4], set = bits [3:2], offset = bits [1:0]. The offset has no effect on lookup. Every memory address the block issues is word-aligned (bits [1:0] = 0).
- R2: A request is accepted on a clock edge with `req_valid` and `req_ready` both high. A hit raises `resp_valid` for one cycle in the next cycle and causes no memory transaction. For a read hit, `resp_rdata` is the stored word.
- R3: A write hit stores `req_wdata` into the line and marks it dirty, without writing memory. A later read of that address hits and returns the new word.
- R4: On a miss, `busy` is high and `req_ready` low from the cycle after acceptance until the refill completes. `resp_valid` follows in the cycle after the refill read handshake.
- R5: A valid, dirty victim is written to memory at the byte address {victim tag, set, 00}, carrying its data, before the refill read is issued.
- R6: A victim that is invalid or clean is replaced without any memory write.
- R7: The victim is the invalid way if exactly one way is invalid, and way 0 if both are invalid. If both ways are valid, the victim is the least recently used way of the set; every hit and every fill makes the other way least recently used.
- R8: A write miss fetches the line, merges the store into it, and leaves it dirty. The merged word reaches memory when the line is later evicted.
- R9: Reset clears all valid, dirty and recency state. After reset `req_ready` = 1, `busy` = 0, `resp_valid` = 0 and `mem_valid` = 0, and any access misses.
- R10: From reset, reads of word addresses 0, 8, 0, 6, 8, 16 give miss, miss, hit, miss, hit, miss.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can take a request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load result (store data on stores) |
| busy | output | 1 | Miss in progress; requester stalled |
| mem_valid | output | 1 | Memory transaction requested |
| mem_ready | input | 1 | Memory accepts / completes the transaction |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 7 | Word-aligned byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, valid with `mem_ready` on reads |

## Verification
Several properties are checked on every cycle:
- memory traffic appears only while the cache is stalled;
- requests to memory stay stable under back-pressure and are word-aligned;
- every write-back is followed directly by a refill read;
- a refill handshake is followed by a response;
- every accepted request leads to either a response or a stall.

Other behaviours only the bench's scenarios can show. These are the hit/miss pattern of the address trace, the choice of least recently used versus empty victims, whether a victim is written back or dropped depending on its dirty bit, the data carried by a write-back, write-allocate merging, and the loss of all cached lines at reset.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/wbc_ways.sv
module wbc_ways
  import wbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int TAG_W  = 3,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              lk_set,
  input  logic [TAG_W-1:0]              lk_tag,
  input  logic                          wr_en,
  input  logic                          wr_way,
  input  logic [IDX_W-1:0]              wr_set,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          wr_dirty,
  output logic [WAYS-1:0]               hit_vec,
  output logic [WAYS-1:0]               line_valid,
  output logic [WAYS-1:0]               line_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]    line_tag,
  output logic [WAYS-1:0][DATA_W-1:0]   line_data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]             vld_q;
    logic [SETS-1:0]             drt_q;
    logic [SETS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][DATA_W-1:0] dat_q;
    logic                        sel;

    assign sel = wr_en && (wr_way == w[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (sel) begin
        vld_q[wr_set] <= 1'b1;
        drt_q[wr_set] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_set] <= wr_tag;
        dat_q[wr_set] <= wr_data;
      end
    end

    assign line_valid[w] = vld_q[lk_set];
    assign line_dirty[w] = drt_q[lk_set];
    assign line_tag[w]   = tag_q[lk_set];
    assign line_data[w]  = dat_q[lk_set];
    assign hit_vec[w]    = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
  end
endmodule

// File: rtl/wbc_lru.sv
module wbc_lru #(
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] rd_set,
  output logic             lru_way
);
  logic [SETS-1:0] older_q;

  always_ff @(posedge clk) begin
    if (!rst_n) older_q <= '0;
    else if (touch) older_q[touch_set] <= ~touch_way;
  end

  assign lru_way = older_q[rd_set];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_we,
  input  logic [WA_W-1:0]             req_word,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        resp_valid,
  output logic [DATA_W-1:0]           resp_rdata,
  output logic                        busy,
  output logic                        mem_valid,
  input  logic                        mem_ready,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  output logic [IDX_W-1:0]            lk_set,
  output logic [TAG_W-1:0]            lk_tag,
  input  logic [WAYS-1:0]             hit_vec,
  input  logic [WAYS-1:0]             line_valid,
  input  logic [WAYS-1:0]             line_dirty,
  input  logic [WAYS-1:0][TAG_W-1:0]  line_tag,
  input  logic [WAYS-1:0][DATA_W-1:0] line_data,
  input  logic                        lru_way,
  output logic                        wr_en,
  output logic                        wr_way,
  output logic [DATA_W-1:0]           wr_data,
  output logic                        wr_dirty,
  output logic                        touch,
  output logic                        touch_way
);
  ctl_state_e        state_q, state_d;
  logic [WA_W-1:0]   word_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              vict_q, vict_d;
  logic              resp_d;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              resp_q;
  logic [WA_W-1:0]   cur_word;
  logic              hit, hit_way, victim;
  logic [DATA_W-1:0] hit_data, fill_word;

  assign cur_word  = (state_q == ST_IDLE) ? req_word : word_q;
  assign lk_tag    = cur_word[WA_W-1 -: TAG_W];
  assign lk_set    = cur_word[IDX_W-1:0];
  assign hit       = |hit_vec;
  assign hit_way   = hit_vec[1];
  assign hit_data  = hit_way ? line_data[1] : line_data[0];
  assign fill_word = we_q ? wdata_q : mem_rdata;

  always_comb begin
    if (!line_valid[0])      victim = 1'b0;
    else if (!line_valid[1]) victim = 1'b1;
    else                     victim = lru_way;
  end

  always_comb begin
    state_d   = state_q;
    vict_d    = vict_q;
    resp_d    = 1'b0;
    rdata_d   = rdata_q;
    wr_en     = 1'b0;
    wr_way    = 1'b0;
    wr_data   = req_wdata;
    wr_dirty  = 1'b0;
    touch     = 1'b0;
    touch_way = 1'b0;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (hit) begin
            touch     = 1'b1;
            touch_way = hit_way;
            resp_d    = 1'b1;
            rdata_d   = req_we ? req_wdata : hit_data;
            if (req_we) begin
              wr_en    = 1'b1;
              wr_way   = hit_way;
              wr_dirty = 1'b1;
            end
          end else begin
            vict_d  = victim;
            state_d = (line_valid[victim] && line_dirty[victim]) ? ST_EVICT : ST_REFILL;
          end
        end
      end
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {line_tag[vict_q], lk_set, {OFF_W{1'b0}}};
        mem_wdata = line_data[vict_q];
        if (mem_ready) state_d = ST_REFILL;
      end
      ST_REFILL: begin
        mem_valid = 1'b1;
        mem_addr  = {word_q, {OFF_W{1'b0}}};
        if (mem_ready) begin
          wr_en     = 1'b1;
          wr_way    = vict_q;
          wr_data   = fill_word;
          wr_dirty  = we_q;
          touch     = 1'b1;
          touch_way = vict_q;
          resp_d    = 1'b1;
          rdata_d   = fill_word;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vict_q  <= 1'b0;
      resp_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      vict_q  <= vict_d;
      resp_q  <= resp_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && req_valid) begin
      word_q  <= req_word;
      we_q    <= req_we;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign resp_valid = resp_q;
  assign resp_rdata = rdata_q;
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int SETS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [IDX_W-1:0]            lk_set;
  logic [TAG_W-1:0]            lk_tag;
  logic [WAYS-1:0]             hit_vec, line_valid, line_dirty;
  logic [WAYS-1:0][TAG_W-1:0]  line_tag;
  logic [WAYS-1:0][DATA_W-1:0] line_data;
  logic                        lru_way;
  logic                        wr_en, wr_way, wr_dirty, touch, touch_way;
  logic [DATA_W-1:0]           wr_data;

  wbc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_word(req_addr[ADDR_W-1:OFF_W]), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .lk_set(lk_set), .lk_tag(lk_tag), .hit_vec(hit_vec),
    .line_valid(line_valid), .line_dirty(line_dirty),
    .line_tag(line_tag), .line_data(line_data), .lru_way(lru_way),
    .wr_en(wr_en), .wr_way(wr_way), .wr_data(wr_data), .wr_dirty(wr_dirty),
    .touch(touch), .touch_way(touch_way)
  );

  wbc_ways #(.DATA_W(DATA_W), .SETS(SETS), .TAG_W(TAG_W)) u_ways (
    .clk(clk), .rst_n(rst_n), .lk_set(lk_set), .lk_tag(lk_tag),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(lk_set), .wr_tag(lk_tag),
    .wr_data(wr_data), .wr_dirty(wr_dirty),
    .hit_vec(hit_vec), .line_valid(line_valid), .line_dirty(line_dirty),
    .line_tag(line_tag), .line_data(line_data)
  );

  wbc_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_set(lk_set),
    .touch_way(touch_way), .rd_set(lk_set), .lru_way(lru_way)
  );
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  assert_mem_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

  assert_evict_then_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> (mem_valid && !mem_we));

  assert_fill_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> (resp_valid && !busy));

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  assert_accept_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (resp_valid || busy));
endmodule

bind wbc_cache wbc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .busy(busy), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, resp_valid, busy;
  logic [31:0] resp_rdata;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [6:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  wbc_cache u_wbc_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [32];
  int n_rd = 0, n_wr = 0, stab_err = 0;
  logic [6:0]  last_wb_addr;
  logic [31:0] last_wb_data;

  // memory model: answers after LAT waiting cycles, driven at falling edges
  initial begin
    int wait_cnt = 0;
    logic [6:0]  h_addr;
    logic [31:0] h_data;
    logic        h_we;
    for (int i = 0; i < 32; i++) mem[i] = 32'hA500_0000 | i;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        if (h_we) begin
          mem[h_addr[6:2]] = h_data;
          n_wr++;
          last_wb_addr = h_addr;
          last_wb_data = h_data;
        end else n_rd++;
        mem_ready = 1'b0;
        wait_cnt  = 0;
      end else if (mem_valid) begin
        if (wait_cnt == 0) begin
          h_addr = mem_addr; h_we = mem_we; h_data = mem_wdata;
        end else if (mem_addr !== h_addr || mem_we !== h_we || mem_wdata !== h_data) begin
          stab_err++;
        end
        if (wait_cnt == LAT) begin
          mem_ready = 1'b1;
          mem_rdata = mem[mem_addr[6:2]];
        end
        wait_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; miss = busy in the cycle after acceptance
  task automatic access(input logic we, input logic [6:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic miss);
    int guard = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    miss = busy;
    if (busy) chk("R4 req_ready low during miss", {31'b0, req_ready}, 32'd0);
    while (!resp_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (!resp_valid) chk("R4 response timeout", 32'd0, 32'd1);
    rd = resp_rdata;
    #1;
  endtask

  localparam int NTR = 6;
  // {expected miss, byte address}
  localparam logic [7:0] TRACE [NTR] = '{
    {1'b1, 7'd0}, {1'b1, 7'd32}, {1'b0, 7'd0},
    {1'b1, 7'd24}, {1'b0, 7'd32}, {1'b1, 7'd64}
  };

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        miss;
    int r0, w0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R9 busy", {31'b0, busy}, 32'd0);
    chk("R9 resp_valid", {31'b0, resp_valid}, 32'd0);
    chk("R9 mem_valid", {31'b0, mem_valid}, 32'd0);
    rst_n = 1'b1;

    // R10 trace table
    for (int i = 0; i < NTR; i++) begin
      access(1'b0, TRACE[i][6:0], '0, rd, miss);
      chk("R10 hit/miss", {31'b0, miss}, {31'b0, TRACE[i][7]});
      chk("R10 data", rd, 32'hA500_0000 | TRACE[i][6:2]);
    end
    chk("R6 no write-backs in trace", n_wr, 0);

    // R3 write hit on word 8
    r0 = n_rd; w0 = n_wr;
    access(1'b1, 7'd32, 32'hDEAD_0008, rd, miss);
    chk("R3 write hit", {31'b0, miss}, 32'd0);
    chk("R2 write hit no traffic", n_rd + n_wr, r0 + w0);
    access(1'b0, 7'd32, '0, rd, miss);
    chk("R3 read after write", rd, 32'hDEAD_0008);
    chk("R3 memory untouched", mem[8], 32'hA500_0008);

    // R7 LRU victim is the clean word 16, not dirty word 8
    access(1'b0, 7'd0, '0, rd, miss);
    chk("R7 miss on word 0", {31'b0, miss}, 32'd1);
    chk("R6 clean victim no write", n_wr, w0);
    access(1'b0, 7'd32, '0, rd, miss);
    chk("R7 word 8 retained", {31'b0, miss}, 32'd0);
    chk("R7 word 8 data", rd, 32'hDEAD_0008);

    // R5 dirty eviction
    access(1'b0, 7'd64, '0, rd, miss);
    chk("R7 word 16 evicts word 0", n_wr, w0);
    access(1'b0, 7'd48, '0, rd, miss);
    chk("R5 write-back count", n_wr, w0 + 1);
    chk("R5 write-back address", {25'b0, last_wb_addr}, 32'd32);
    chk("R5 write-back data", last_wb_data, 32'hDEAD_0008);
    chk("R5 refill data", rd, 32'hA500_000C);

    // R1 offset ignored
    access(1'b0, 7'd50, '0, rd, miss);
    chk("R1 offset hit", {31'b0, miss}, 32'd0);
    chk("R1 offset data", rd, 32'hA500_000C);

    // R8 write miss allocate
    w0 = n_wr;
    access(1'b1, 7'h1C, 32'hCAFE_0007, rd, miss);
    chk("R8 write miss", {31'b0, miss}, 32'd1);
    chk("R8 no write-back", n_wr, w0);
    access(1'b0, 7'h1C, '0, rd, miss);
    chk("R8 merged read hit", {31'b0, miss}, 32'd0);
    chk("R8 merged data", rd, 32'hCAFE_0007);
    access(1'b0, 7'h3C, '0, rd, miss);
    chk("R7 invalid way used", n_wr, w0);
    access(1'b0, 7'h5C, '0, rd, miss);
    chk("R8 evicted merged data", mem[7], 32'hCAFE_0007);
    chk("R8 eviction address", {25'b0, last_wb_addr}, 32'h1C);
    access(1'b0, 7'd32, '0, rd, miss);
    chk("R5 reload written-back word", rd, 32'hDEAD_0008);

    // R9 reset clears contents
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 busy after reset", {31'b0, busy}, 32'd0);
    rst_n = 1'b1;
    access(1'b0, 7'h5C, '0, rd, miss);
    chk("R9 miss after reset", {31'b0, miss}, 32'd1);
    chk("R9 data after reset", rd, 32'hA500_0017);

    chk("R11 memory request stable", stab_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule